// File: doc/BRIEF.md
# Sequenced Status Reporter

This block sits in one module and forwards its status to a shared status readback path. Software configures it with a single 8-bit control write. The write selects one of four reporting modes and loads a 6-bit sequence number. A report is a registered word that carries the module's status bits with the sequence number packed alongside them. It is marked by a one-cycle valid pulse toward the status router.

Software polls the readback location. It compares the masked status bits against a pattern, looking for either equality or a difference. It can also wait until the sequence field moves away from the last value it saw, which tells it that the readback is fresh. In the automatic modes the block reports whenever the monitored status input changes. In the incrementing mode the sequence number advances after every report, so each new report can be told apart from the one before it.

Top module: `stat_reporter`

## Requirements
- R1: The control byte holds the mode in bits [7:6] and the sequence number in bits [5:0]. Both take effect on the clock edge that samples the write, and no report is issued on that edge.
- R2: The report word is 26 bits wide. The sampled status input occupies bits [19:0] and the sequence number occupies bits [25:20]. The word is registered and holds its value between reports.
- R3: Mode 0 (00) issues no report at all, whatever the status input does.
- R4: Mode 1 (01) issues exactly one report, on the edge after the control write. After that it issues none, even when the status input changes.
- R5: Mode 2 (10) issues a report on the edge after the write. It then reports on every edge where the status input differs from its value at the previous edge, and the sequence number does not change.
- R6: Mode 3 (11) reports on the same events as mode 2. The sequence number increases by one after each report and wraps from 63 to 0.
- R7: A control write reloads the sequence number immediately and takes priority over a report due on the same edge. The pending report then goes out on the next edge, carrying the new sequence number and the status at that edge.
- R8: Report-valid is high for exactly one cycle per triggering edge, with at most one report per cycle. After reset, report-valid is 0 and the report word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control write strobe |
| ctl_data | input | 8 | Control value: mode [7:6], sequence [5:0] |
| stat_in | input | 20 | Monitored status bits |
| rpt_valid | output | 1 | Report strobe, one cycle per report |
| rpt_data | output | 26 | Report word: sequence [25:20], status [19:0] |

## Verification
The bench drives the status input so that it changes on consecutive edges while in the automatic modes. A design that merged back-to-back changes, or reported against a stale baseline, would lose reports or emit extra ones. The incrementing mode is pushed through the sequence wrap from 63 to 0; an off-by-one or a wrong width would corrupt the sequence field. A control write is placed on an edge where the status also changes. A design that let the report win would carry the old sequence number and skip the reload. The single-shot and off modes are hit with status changes afterward, which catches any stray report.

// File: rtl/stat_rpt_pkg.sv
package stat_rpt_pkg;
   typedef enum logic [1:0] {
      RPT_OFF  = 2'd0,
      RPT_ONCE = 2'd1,
      RPT_HOLD = 2'd2,
      RPT_STEP = 2'd3
   } rpt_mode_e;
endpackage

// File: rtl/stat_rpt_ctl.sv
module stat_rpt_ctl
   import stat_rpt_pkg::*;
#(
   parameter int SEQ_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  rpt_mode_e        wr_mode,
   input  logic [SEQ_W-1:0] wr_seq,
   input  logic             fire,
   output rpt_mode_e        mode_q,
   output logic [SEQ_W-1:0] seq_q,
   output logic             pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= RPT_OFF;
         seq_q  <= '0;
         pend_q <= 1'b0;
      end else if (wr_en) begin
         mode_q <= wr_mode;
         seq_q  <= wr_seq;
         pend_q <= (wr_mode != RPT_OFF);
      end else if (fire) begin
         pend_q <= 1'b0;
         if (mode_q == RPT_STEP) seq_q <= seq_q + 1'b1;
      end
   end

   // R6: stepping mode advances the sequence after a report
   assert_seq_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !wr_en && mode_q == RPT_STEP) |=> seq_q == $past(seq_q) + 1'b1);
   // R5: holding mode keeps the sequence
   assert_seq_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && mode_q != RPT_STEP) |=> $stable(seq_q));
endmodule

// File: rtl/stat_rpt_trig.sv
module stat_rpt_trig
   import stat_rpt_pkg::*;
#(
   parameter int STAT_BITS = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [STAT_BITS-1:0] stat_in,
   input  rpt_mode_e            mode,
   input  logic                 pend,
   input  logic                 wr_en,
   output logic                 fire
);
   logic [STAT_BITS-1:0] last_q;
   logic                 changed;
   logic                 auto_md;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= '0;
      else        last_q <= stat_in;
   end

   always_comb begin
      changed = (stat_in != last_q);
      auto_md = (mode == RPT_HOLD) || (mode == RPT_STEP);
      fire    = !wr_en && (mode != RPT_OFF) && (pend || (auto_md && changed));
   end
endmodule

// File: rtl/stat_rpt_out.sv
module stat_rpt_out #(
   parameter int STAT_BITS  = 20,
   parameter int SEQ_W      = 6,
   parameter bit SEQ_AT_TOP = 1'b1,
   localparam int WORD_W    = STAT_BITS + SEQ_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fire,
   input  logic [SEQ_W-1:0]     seq,
   input  logic [STAT_BITS-1:0] stat,
   output logic                 rpt_valid,
   output logic [WORD_W-1:0]    rpt_data
);
   logic [WORD_W-1:0] word;

   generate
      if (SEQ_AT_TOP) begin : g_seq_hi
         assign word = {seq, stat};
      end else begin : g_seq_lo
         assign word = {stat, seq};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rpt_valid <= 1'b0;
         rpt_data  <= '0;
      end else begin
         rpt_valid <= fire;
         if (fire) rpt_data <= word;
      end
   end

   // R2: word is held between reports
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !fire |=> $stable(rpt_data));
endmodule

// File: rtl/stat_reporter.sv
module stat_reporter
   import stat_rpt_pkg::*;
#(
   parameter int STAT_BITS  = 20,
   parameter int SEQ_W      = 6,
   parameter bit SEQ_AT_TOP = 1'b1,
   localparam int CTL_W     = SEQ_W + 2,
   localparam int WORD_W    = STAT_BITS + SEQ_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctl_we,
   input  logic [CTL_W-1:0]     ctl_data,
   input  logic [STAT_BITS-1:0] stat_in,
   output logic                 rpt_valid,
   output logic [WORD_W-1:0]    rpt_data
);
   generate
      if (WORD_W > 32) begin : g_bad_width
         $error("status word wider than 32 bits");
      end
      if (SEQ_W < 1 || STAT_BITS < 1) begin : g_bad_field
         $error("empty field");
      end
   endgenerate

   rpt_mode_e        mode_q;
   logic [SEQ_W-1:0] seq_q;
   logic             pend_q;
   logic             fire;
   rpt_mode_e        wr_mode;

   assign wr_mode = rpt_mode_e'(ctl_data[CTL_W-1 -: 2]);

   stat_rpt_ctl #(.SEQ_W(SEQ_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_mode(wr_mode),
      .wr_seq(ctl_data[SEQ_W-1:0]), .fire(fire),
      .mode_q(mode_q), .seq_q(seq_q), .pend_q(pend_q)
   );

   stat_rpt_trig #(.STAT_BITS(STAT_BITS)) u_trig (
      .clk(clk), .rst_n(rst_n), .stat_in(stat_in), .mode(mode_q),
      .pend(pend_q), .wr_en(ctl_we), .fire(fire)
   );

   stat_rpt_out #(.STAT_BITS(STAT_BITS), .SEQ_W(SEQ_W), .SEQ_AT_TOP(SEQ_AT_TOP)) u_out (
      .clk(clk), .rst_n(rst_n), .fire(fire), .seq(seq_q), .stat(stat_in),
      .rpt_valid(rpt_valid), .rpt_data(rpt_data)
   );

   // R1: the write loads mode and sequence
   assert_ctl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (seq_q == $past(ctl_data[SEQ_W-1:0]) && mode_q == $past(wr_mode)));
   // R7: no report on a write edge
   assert_wr_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> !rpt_valid);
   // R3: off mode is silent
   assert_off_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RPT_OFF && !ctl_we) |=> !rpt_valid);
   // R4: single-shot mode is silent once its report is out
   assert_once_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == RPT_ONCE && !pend_q && !ctl_we) |=> !rpt_valid);
endmodule

// File: tb/sim_stat_reporter.sv
`timescale 1ns/1ps
module sim_stat_reporter;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_data = '0;
   logic [19:0] stat_in = '0;
   logic        rpt_valid;
   logic [25:0] rpt_data;

   int compared = 0;
   int mismatched = 0;
   bit done = 1'b0;

   // reference model state
   int          m_mode = 0;
   int          m_seq = 0;
   bit          m_pend = 0;
   logic [19:0] m_last = '0;
   bit          m_v = 0;
   logic [25:0] m_d = '0;

   always #4 clk = ~clk;

   stat_reporter u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_data(ctl_data),
      .stat_in(stat_in), .rpt_valid(rpt_valid), .rpt_data(rpt_data)
   );

   task automatic cmp(input string tag);
      compared++;
      if (rpt_valid !== m_v || rpt_data !== m_d) begin
         mismatched++;
         $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
                  tag, rpt_valid, rpt_data, m_v, m_d);
      end
   endtask

   task automatic step(input logic we, input logic [7:0] cd,
                       input logic [19:0] st, input string tag);
      bit fire;
      ctl_we = we; ctl_data = cd; stat_in = st;
      @(posedge clk);
      fire = !we && m_mode != 0 && (m_pend || (m_mode >= 2 && st != m_last));
      if (we) begin
         m_mode = int'(cd[7:6]);
         m_seq  = int'(cd[5:0]);
         m_pend = (cd[7:6] != 2'd0);
         m_v    = 0;
      end else begin
         m_v = fire;
         if (fire) begin
            m_d    = {6'(m_seq), st};
            m_pend = 0;
            if (m_mode == 3) m_seq = (m_seq + 1) % 64;
         end
      end
      m_last = st;
      @(negedge clk);
      cmp(tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         mismatched++;
         $display("FAIL watchdog: valid=%0b data=%h expected run to finish", rpt_valid, rpt_data);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      cmp("R8 reset");
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R8 reset");
      // R3: off mode with a changing status
      step(1, 8'h05, 20'h00001, "R1");
      for (int i = 0; i < 4; i++) step(0, 8'h00, 20'h00010 + 20'(i), "R3");
      // R4: single report, then silence
      step(1, 8'h49, 20'h00100, "R4");
      for (int i = 0; i < 5; i++) step(0, 8'h00, 20'h00200 + 20'(i * 3), "R4");
      // R5: hold mode, report on change, consecutive changes
      step(1, 8'hAA, 20'hABCDE, "R5");
      step(0, 8'h00, 20'hABCDE, "R5");
      step(0, 8'h00, 20'hABCDE, "R2");
      step(0, 8'h00, 20'h12345, "R5");
      step(0, 8'h00, 20'h12346, "R8");
      step(0, 8'h00, 20'h12347, "R8");
      step(0, 8'h00, 20'h12347, "R2");
      // R6: stepping mode with wrap
      step(1, 8'hFD, 20'h00000, "R6");
      for (int i = 1; i <= 6; i++) step(0, 8'h00, 20'(i * 7), "R6");
      step(0, 8'h00, 20'(42), "R2");
      // R7: write on the same edge as a status change
      step(0, 8'h00, 20'hF0F0F, "R7");
      step(1, 8'hD0, 20'h0F0F0, "R7");
      step(0, 8'h00, 20'h0F0F0, "R7");
      step(0, 8'h00, 20'h0F0F1, "R7");
      // R3: back to off stops reports
      step(1, 8'h00, 20'h11111, "R3");
      for (int i = 0; i < 4; i++) step(0, 8'h00, 20'h22220 + 20'(i), "R3");
      // R1: rewrite in hold mode with a new sequence
      step(1, 8'h81, 20'h33333, "R1");
      step(0, 8'h00, 20'h33333, "R1");
      step(0, 8'h00, 20'h44444, "R5");
      step(0, 8'h00, 20'h44444, "R2");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule